// File: doc/BRIEF.md
# Buffered Update Register for a Current-Output DAC

This block sits between a byte-wide register write port and the switch bank of a 10-bit current-output converter. Firmware writes a control byte and two data bytes. The data is left-justified: the high byte carries the upper eight code bits, and the top two bits of the low byte carry the two lowest code bits. Written data first lands in holding registers. It is copied into the output code register only when the selected update trigger fires. The trigger can be a high-byte write, a one-cycle timer overflow pulse, or an edge on an asynchronous convert-start pin.

The output code drives one switch per bit of a binary-weighted current source bank, where a 1 closes the switch. The block also passes an enable bit and a full-scale range selection to the analog side. One step of output current is the selected full scale divided by 1024. The write port follows valid/ready rules. `wr_ready` is held high at all times, so a write is accepted in every cycle where `wr_valid` is high and there is never back-pressure. Firmware should write the low byte before the high byte, so that a write-triggered update sees a consistent word.

Address map: 0 is control, 1 is the low data byte, 2 is the high data byte, and 3 is unused. Control byte fields:

| Bits | Field |
|------|-------|
| 7 | enable |
| 6:4 | update mode |
| 3 | edge polarity (1 = rising, 0 = falling) |
| 2 | ignored |
| 1:0 | range |

Update mode codes:

| Code | Trigger |
|------|---------|
| 111 | high-byte write |
| 000 | timer overflow |
| 001 | pin edge |
| any other | never updates |

Range codes:

| Code | Full scale |
|------|------------|
| 00 | 0.5 mA |
| 01 | 1 mA |
| 10 | 2 mA |

Top module: `cdac_update_ctrl`

## Requirements
- R1: After reset `dac_code` is 0, `sw_ctl` is 0, `dac_en` is 0, `range_sel` is 00, and the update mode is 111 (high-byte write).
- R2: Code mapping is left-justified: `dac_code[9:2]` comes from a high-byte write (address 2) and `dac_code[1:0]` comes from bits 7:6 of the low-byte write (address 1).
- R3: In mode 111, a high-byte write loads {written high byte, held low bits} into `dac_code` at the clock edge that accepts the write. A low-byte write alone leaves `dac_code` unchanged.
- R4: In mode 000, writes are only held. A `tmr_ovf` pulse loads the held code at the edge where it is sampled. Repeated pulses reload the same value. A data write accepted in the same cycle as the pulse takes effect only on the next pulse.
- R5: In mode 001, `conv_pin` passes through a two-flop synchronizer. An edge of the polarity chosen by control bit 3 loads the held code on the third rising clock edge after the pin changes. An edge of the other direction causes no load.
- R6: A trigger from a source that the current mode does not select has no effect on `dac_code`. Mode codes other than 111, 000 and 001 never update `dac_code`.
- R7: `dac_en` follows control bit 7. `sw_ctl` equals `dac_code` while enabled and is all zero while disabled.
- R8: `range_sel` takes control bits 1:0 with 00 = 0.5 mA, 01 = 1 mA and 10 = 2 mA. A written 11 is stored as 10.
- R9: `wr_ready` is always 1. A write to address 3 changes neither the control settings nor `dac_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Write data byte |
| tmr_ovf | input | 1 | One-cycle timer overflow pulse |
| conv_pin | input | 1 | Asynchronous convert-start pin |
| dac_code | output | 10 | Output code register |
| sw_ctl | output | 10 | Current-source switch controls, gated by enable |
| dac_en | output | 1 | Analog enable |
| range_sel | output | 2 | Full-scale range select |

## Verification
Write-triggered and timer-triggered loads show up on `dac_code` right after the clock edge that samples the write or pulse. The bench drives inputs on a falling edge and compares at the next falling edge, one edge later. Pin-triggered loads need three rising edges. The bench therefore checks that the code is still unchanged after the first and second edges, and checks the new value only after the third. Control fields (`dac_en`, `range_sel`, and the gating of `sw_ctl`) change one edge after the control write is accepted, and are sampled in the same way.

// File: rtl/cdac_pkg.sv
package cdac_pkg;
  localparam int unsigned CODE_W = 10;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LO_W   = CODE_W - BYTE_W;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_LO   = 2'd1,
    ADR_HI   = 2'd2,
    ADR_NONE = 2'd3
  } addr_e;

  typedef enum logic [2:0] {
    MODE_TIMER = 3'b000,
    MODE_PIN   = 3'b001,
    MODE_WRITE = 3'b111
  } mode_e;

  typedef enum logic [1:0] {
    RNG_HALF_MA = 2'b00,
    RNG_ONE_MA  = 2'b01,
    RNG_TWO_MA  = 2'b10
  } range_e;

  typedef struct packed {
    logic       en;
    logic [2:0] mode;
    logic       rise;
    logic [1:0] range;
  } ctrl_t;
endpackage

// File: rtl/cdac_wr_regs.sv
module cdac_wr_regs
  import cdac_pkg::*;
#(
  parameter int unsigned CW = CODE_W,
  parameter int unsigned BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic [1:0]    wr_addr,
  input  logic [BW-1:0] wr_data,
  output ctrl_t         ctrl_q,
  output logic          hi_wr,
  output logic [CW-1:0] held_code
);
  localparam int unsigned LW = CW - BW;

  logic [BW-1:0] hi_q;
  logic [LW-1:0] lo_q;
  logic          ctrl_wr;
  logic          lo_wr;
  logic [1:0]    range_in;

  assign ctrl_wr = wr_fire && (wr_addr == ADR_CTRL);
  assign lo_wr   = wr_fire && (wr_addr == ADR_LO);
  assign hi_wr   = wr_fire && (wr_addr == ADR_HI);

  // A written range of 11 saturates to the largest legal setting.
  assign range_in = (wr_data[1:0] == 2'b11) ? RNG_TWO_MA : wr_data[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{en: 1'b0, mode: MODE_WRITE, rise: 1'b0, range: RNG_HALF_MA};
    end else if (ctrl_wr) begin
      ctrl_q <= '{en: wr_data[7], mode: wr_data[6:4], rise: wr_data[3], range: range_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_wr) hi_q <= wr_data;
      if (lo_wr) lo_q <= wr_data[BW-1 -: LW];
    end
  end

  assign held_code = {hi_q, lo_q};
endmodule

// File: rtl/cdac_pin_edge.sv
module cdac_pin_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic rise_sel,
  output logic edge_hit
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  for (genvar i = 0; i < STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= pin_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  assign edge_hit = rise_sel ? (cur && !prev_q) : (!cur && prev_q);
endmodule

// File: rtl/cdac_trig_sel.sv
module cdac_trig_sel
  import cdac_pkg::*;
#(
  parameter int unsigned CW = CODE_W,
  parameter int unsigned BW = BYTE_W
) (
  input  logic [2:0]    mode,
  input  logic          hi_wr,
  input  logic [BW-1:0] hi_byte,
  input  logic          tmr_ovf,
  input  logic          pin_edge,
  input  logic [CW-1:0] held_code,
  output logic          load_now,
  output logic [CW-1:0] load_code
);
  localparam int unsigned LW = CW - BW;

  always_comb begin
    load_now  = 1'b0;
    load_code = held_code;
    unique case (mode)
      MODE_WRITE: begin
        load_now  = hi_wr;
        load_code = {hi_byte, held_code[LW-1:0]};
      end
      MODE_TIMER: load_now = tmr_ovf;
      MODE_PIN:   load_now = pin_edge;
      default:    load_now = 1'b0;
    endcase
  end
endmodule

// File: rtl/cdac_update_ctrl.sv
module cdac_update_ctrl
  import cdac_pkg::*;
#(
  parameter int unsigned CW          = CODE_W,
  parameter int unsigned BW          = BYTE_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [1:0]    wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic          tmr_ovf,
  input  logic          conv_pin,
  output logic [CW-1:0] dac_code,
  output logic [CW-1:0] sw_ctl,
  output logic          dac_en,
  output logic [1:0]    range_sel
);
  ctrl_t         ctrl_q;
  logic          wr_fire;
  logic          hi_wr;
  logic          pin_edge;
  logic          load_now;
  logic [CW-1:0] held_code;
  logic [CW-1:0] load_code;
  logic [CW-1:0] code_q;
  logic [2:0]    mode_q;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;
  assign mode_q   = ctrl_q.mode;

  cdac_wr_regs #(.CW(CW), .BW(BW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (wr_fire),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ctrl_q    (ctrl_q),
    .hi_wr     (hi_wr),
    .held_code (held_code)
  );

  cdac_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (conv_pin),
    .rise_sel  (ctrl_q.rise),
    .edge_hit  (pin_edge)
  );

  cdac_trig_sel #(.CW(CW), .BW(BW)) u_trig (
    .mode      (mode_q),
    .hi_wr     (hi_wr),
    .hi_byte   (wr_data),
    .tmr_ovf   (tmr_ovf),
    .pin_edge  (pin_edge),
    .held_code (held_code),
    .load_now  (load_now),
    .load_code (load_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        code_q <= '0;
    else if (load_now) code_q <= load_code;
  end

  assign dac_code  = code_q;
  assign dac_en    = ctrl_q.en;
  assign range_sel = ctrl_q.range;
  assign sw_ctl    = ctrl_q.en ? code_q : '0;
endmodule

// File: rtl/cdac_update_chk.sv
module cdac_update_chk
  import cdac_pkg::*;
#(
  parameter int unsigned CW = CODE_W,
  parameter int unsigned BW = BYTE_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic [1:0]    wr_addr,
  input logic [BW-1:0] wr_data,
  input logic          tmr_ovf,
  input logic [CW-1:0] dac_code,
  input logic [CW-1:0] sw_ctl,
  input logic          dac_en,
  input logic [1:0]    range_sel,
  input logic [2:0]    mode_q,
  input logic          load_now,
  input logic [CW-1:0] held_code
);
  AST_SW_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_en |-> (sw_ctl == '0)); // R7
  AST_CODE_HOLDS_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_now |=> $stable(dac_code)); // R6
  AST_LO_WRITE_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == ADR_LO && mode_q == MODE_WRITE) |=> $stable(dac_code)); // R3
  AST_HI_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == ADR_HI && mode_q == MODE_WRITE)
      |=> (dac_code[CW-1 -: BW] == $past(wr_data))); // R2
  AST_TIMER_LOADS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TIMER && tmr_ovf) |=> (dac_code == $past(held_code))); // R4
  AST_RANGE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    range_sel != 2'b11); // R8
endmodule

bind cdac_update_ctrl cdac_update_chk #(.CW(CW), .BW(BW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .tmr_ovf   (tmr_ovf),
  .dac_code  (dac_code),
  .sw_ctl    (sw_ctl),
  .dac_en    (dac_en),
  .range_sel (range_sel),
  .mode_q    (mode_q),
  .load_now  (load_now),
  .held_code (held_code)
);

// File: tb/cdac_update_ctrl_bench.sv
`timescale 1ns/1ps
module cdac_update_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       tmr_ovf = 1'b0;
  logic       conv_pin = 1'b0;
  logic [9:0] dac_code;
  logic [9:0] sw_ctl;
  logic       dac_en;
  logic [1:0] range_sel;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cdac_update_ctrl u_cdac_update_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .tmr_ovf(tmr_ovf), .conv_pin(conv_pin),
    .dac_code(dac_code), .sw_ctl(sw_ctl), .dac_en(dac_en), .range_sel(range_sel)
  );

  // {kind(0 write, 1 timer pulse), addr, data, expected code, expected switches}
  localparam int NV = 15;
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 2'd0, 8'hF2, 10'h000, 10'h000}, // enable, write mode
    {2'd0, 2'd1, 8'hC0, 10'h000, 10'h000}, // R3 low only: no load
    {2'd0, 2'd2, 8'hA5, 10'h297, 10'h297}, // R2 mapping
    {2'd0, 2'd1, 8'h40, 10'h297, 10'h297},
    {2'd0, 2'd2, 8'h00, 10'h001, 10'h001},
    {2'd0, 2'd2, 8'hFF, 10'h3FD, 10'h3FD},
    {2'd0, 2'd1, 8'hC0, 10'h3FD, 10'h3FD},
    {2'd0, 2'd2, 8'hFF, 10'h3FF, 10'h3FF}, // all switches on
    {2'd1, 2'd0, 8'h00, 10'h3FF, 10'h3FF}, // R6 timer ignored in write mode
    {2'd0, 2'd0, 8'h02, 10'h3FF, 10'h000}, // R7 disabled gating
    {2'd0, 2'd0, 8'h82, 10'h3FF, 10'h3FF},
    {2'd0, 2'd2, 8'h12, 10'h3FF, 10'h3FF}, // R4 held
    {2'd0, 2'd1, 8'h80, 10'h3FF, 10'h3FF},
    {2'd1, 2'd0, 8'h00, 10'h04A, 10'h04A}, // R4 load
    {2'd1, 2'd0, 8'h00, 10'h04A, 10'h04A}  // R4 reload
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit wr, input bit tmr, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = wr; wr_addr = a; wr_data = d; tmr_ovf = tmr;
    @(negedge clk);
    wr_valid = 1'b0; tmr_ovf = 1'b0;
  endtask

  task automatic pin_to(input logic v, input int exp_old, input int exp_new, input string req);
    @(negedge clk);
    conv_pin = v;
    @(negedge clk); check({req, " edge+1"}, dac_code, exp_old);
    @(negedge clk); check({req, " edge+2"}, dac_code, exp_old);
    @(negedge clk); check({req, " edge+3"}, dac_code, exp_new);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 code", dac_code, 0);
    check("R1 sw", sw_ctl, 0);
    check("R1 en", dac_en, 0);
    check("R1 range", range_sel, 0);
    check("R9 ready", wr_ready, 1);
    step(1'b0, 1'b0, 2'd2, 8'h00); // idle
    step(1'b1, 1'b0, 2'd2, 8'h40); // R1 default mode is write-triggered
    check("R1 default mode", dac_code, 10'h100);
    step(1'b1, 1'b0, 2'd2, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][31:30] == 2'd0, VEC[i][31:30] == 2'd1, VEC[i][29:28], VEC[i][27:20]);
      check($sformatf("table %0d code R2/R3/R4", i), dac_code, VEC[i][19:10]);
      check($sformatf("table %0d sw R7", i), sw_ctl, VEC[i][9:0]);
    end

    // R4: write in the same cycle as a timer pulse waits for the next pulse
    step(1'b1, 1'b1, 2'd2, 8'h55);
    check("R4 same-cycle write", dac_code, 10'h04A);
    step(1'b0, 1'b1, 2'd0, 8'h00);
    check("R4 next pulse", dac_code, 10'h156);

    // R5: pin mode, rising polarity
    step(1'b1, 1'b0, 2'd0, 8'h98);
    step(1'b1, 1'b0, 2'd2, 8'h80);
    step(1'b1, 1'b0, 2'd1, 8'h00);
    check("R5 held before edge", dac_code, 10'h156);
    pin_to(1'b1, 10'h156, 10'h200, "R5 rising");
    step(1'b1, 1'b0, 2'd2, 8'h01);
    step(1'b0, 1'b1, 2'd0, 8'h00);
    check("R6 timer ignored in pin mode", dac_code, 10'h200);
    // R5: falling polarity
    step(1'b1, 1'b0, 2'd0, 8'h90);
    pin_to(1'b0, 10'h200, 10'h004, "R5 falling");
    step(1'b1, 1'b0, 2'd2, 8'h02);
    pin_to(1'b1, 10'h004, 10'h004, "R5 wrong direction");

    // R6: reserved mode never loads
    step(1'b1, 1'b0, 2'd0, 8'hB0);
    step(1'b1, 1'b0, 2'd2, 8'h33);
    step(1'b0, 1'b1, 2'd0, 8'h00);
    check("R6 reserved mode", dac_code, 10'h004);

    // R9: address 3 ignored
    step(1'b1, 1'b0, 2'd0, 8'hF0);
    step(1'b1, 1'b0, 2'd3, 8'h00);
    check("R9 addr3 en", dac_en, 1);
    check("R9 addr3 range", range_sel, 0);
    check("R9 addr3 code", dac_code, 10'h004);

    // R8: range mapping and saturation
    step(1'b1, 1'b0, 2'd0, 8'hF1);
    check("R8 range 01", range_sel, 1);
    step(1'b1, 1'b0, 2'd0, 8'hF3);
    check("R8 range 11 saturates", range_sel, 2);
    step(1'b1, 1'b0, 2'd0, 8'h70);
    check("R7 disable en", dac_en, 0);
    check("R7 disable sw", sw_ctl, 0);
    check("R7 code kept", dac_code, 10'h004);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule